// File: doc/BRIEF.md
# Mixed-Criticality Hardware Thread Dispatch Selector

This block picks, every clock cycle, which hardware thread of a fine-grained interleaved pipeline may issue one instruction. Each thread is marked either deterministic (hard) or best-effort (soft). Hard threads own fixed positions in a repeating 16-position slot table. A 4-bit slot counter steps through the table once per cycle, so each owner issues at an exact, periodic cadence. Power-of-two spacings such as every 2nd, 4th, 8th or 16th position give duty cycles of 1/2 to 1/16. Because each table position holds only one owner, the reservations can never overlap.

A position that has no owner, or whose owner cannot issue this cycle, goes to an eligible soft thread picked by a round-robin pointer. A soft thread may also own table positions, which gives it a guaranteed minimum rate. A thread is eligible when it is active, not stalled, and not parked. A thread is parked by a sleep request and released by a wake request from the interrupt controller. The table can be written only while the block is held in its configuration state. That state also freezes dispatch and rewinds the slot counter and the round-robin pointer, so a new schedule always starts at slot 0.

Top module: `mt_dispatch_sched`

## Requirements
- R1: After reset the table holds no owners, no thread is parked, the slot counter is 0 and the round-robin search begins at thread 0.
- R2: At most one thread is selected per cycle. `disp_onehot` has exactly the bit `disp_tid` set when `disp_valid` is 1, and is all zero otherwise.
- R3: When the current slot's table entry is valid and its owner thread is eligible, that owner is dispatched, whatever its mode.
- R4: The cycles in which a hard thread issues depend only on the table and its own eligibility, not on the activity of any soft thread.
- R5: In a slot that is unowned, or whose owner is not eligible, the dispatched thread is the first eligible soft thread found searching upward, with wrap-around, from the thread after the last round-robin grant.
- R6: A hard thread (`thr_hard` bit 1) is never dispatched in a slot it does not own.
- R7: A `sleep_req` pulse parks a thread from the next cycle on, and its owned slots then go to soft threads. A `wake_req` pulse releases it, so it issues again in its next owned slot. When both arrive in the same cycle, the wake wins.
- R8: With a single active soft thread and an empty table, that thread is dispatched every cycle.
- R9: When no thread qualifies in a cycle, `disp_valid` is 0.
- R10: While `cfg_mode` is 1 nothing is dispatched and table writes take effect. While it is 0, table writes are ignored and the slot counter advances by one each cycle, wrapping 15 to 0. The counter reads slot 0 in the first cycle after `cfg_mode` falls.
- R11: The round-robin pointer moves only on a round-robin grant. A soft thread issuing in a slot it owns leaves the pointer unchanged.
- R12: A thread with its `thr_stall` bit set, or its `thr_active` bit clear, is not dispatched in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration hold: table writable, no dispatch, counter and pointer rewound |
| tbl_we | input | 1 | Table write strobe, honoured only in configuration |
| tbl_addr | input | 4 | Table position to write |
| tbl_own_vld | input | 1 | Written position has an owner |
| tbl_own_tid | input | 2 | Owner thread index |
| thr_hard | input | 4 | Per-thread mode, 1 = hard, 0 = soft |
| thr_active | input | 4 | Per-thread active flag |
| thr_stall | input | 4 | Per-thread stall for this cycle |
| sleep_req | input | 4 | Per-thread park request pulse |
| wake_req | input | 4 | Per-thread wake request pulse from the interrupt controller |
| disp_valid | output | 1 | An instruction is issued this cycle |
| disp_tid | output | 2 | Index of the selected thread |
| disp_onehot | output | 4 | One-hot form of the selected thread |

## Verification
The main function is tried with four kinds of patterns. The first mixes one hard owner every fourth slot with two soft threads. This separates table ownership from round-robin alternation in the leftover slots. The second removes all soft activity, which shows that the hard thread's cadence does not move and that idle slots become bubbles. The third lets soft threads own slots, which tells a reserved grant apart from a round-robin grant through the pointer's next choice. Sleep, wake, stall and writes made outside configuration are each applied in a cycle just before an owned slot. The slot then shows whether the owner or a soft thread took it.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int unsigned DEF_NTHR  = 4;
    localparam int unsigned DEF_SLOTS = 16;

    typedef enum logic {
        MODE_SOFT = 1'b0,
        MODE_HARD = 1'b1
    } thr_mode_e;
endpackage

// File: rtl/sched_slot_table.sv
module sched_slot_table #(
    parameter int unsigned SLOTS = 16,
    parameter int unsigned TID_W = 2,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  logic              wvld,
    input  logic [TID_W-1:0]  wtid,
    input  logic [SLOT_W-1:0] raddr,
    output logic              rvld,
    output logic [TID_W-1:0]  rtid
);
    localparam int unsigned ENT_W = TID_W + 1;

    logic [SLOTS-1:0][ENT_W-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (we) tab_d[waddr] = {wvld, wtid};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign rvld = tab_q[raddr][TID_W];
    assign rtid = tab_q[raddr][TID_W-1:0];

    // R10: the table only changes when a write is accepted
    a_r10_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(tab_q));
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
    parameter int unsigned NTHR  = 4,
    localparam int unsigned TID_W = $clog2(NTHR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [NTHR-1:0]  req,
    input  logic             take,
    output logic             gnt_vld,
    output logic [TID_W-1:0] gnt_id
);
    logic [TID_W-1:0] ptr_d, ptr_q;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_id  = ptr_q;
        for (int k = 1; k <= int'(NTHR); k++) begin
            int unsigned j;
            j = (int'(ptr_q) + k) % NTHR;
            if (!gnt_vld && req[j]) begin
                gnt_vld = 1'b1;
                gnt_id  = TID_W'(j);
            end
        end
    end

    always_comb begin
        ptr_d = ptr_q;
        if (restart)                ptr_d = TID_W'(NTHR - 1);
        else if (take && gnt_vld)   ptr_d = gnt_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= TID_W'(NTHR - 1);
        else        ptr_q <= ptr_d;
    end

    // R11: pointer holds unless a round-robin grant is taken
    a_r11_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(take && gnt_vld)) |=> $stable(ptr_q));
    // R5: a grant always lands on a requester
    a_r5_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> req[gnt_id]);
endmodule

// File: rtl/sched_wait_track.sv
module sched_wait_track #(
    parameter int unsigned NTHR = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTHR-1:0] sleep_req,
    input  logic [NTHR-1:0] wake_req,
    output logic [NTHR-1:0] parked
);
    logic [NTHR-1:0] park_d, park_q;

    always_comb begin
        park_d = (park_q | sleep_req) & ~wake_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) park_q <= '0;
        else        park_q <= park_d;
    end

    assign parked = park_q;

    for (genvar i = 0; i < int'(NTHR); i++) begin : g_chk
        // R7: a wake request always releases the thread, even with a sleep request
        a_r7_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
            wake_req[i] |=> !park_q[i]);
        a_r7_sleep_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (sleep_req[i] && !wake_req[i]) |=> park_q[i]);
    end
endmodule

// File: rtl/mt_dispatch_sched.sv
module mt_dispatch_sched #(
    parameter int unsigned NTHR  = sched_pkg::DEF_NTHR,
    parameter int unsigned SLOTS = sched_pkg::DEF_SLOTS,
    localparam int unsigned TID_W  = $clog2(NTHR),
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              tbl_we,
    input  logic [SLOT_W-1:0] tbl_addr,
    input  logic              tbl_own_vld,
    input  logic [TID_W-1:0]  tbl_own_tid,
    input  logic [NTHR-1:0]   thr_hard,
    input  logic [NTHR-1:0]   thr_active,
    input  logic [NTHR-1:0]   thr_stall,
    input  logic [NTHR-1:0]   sleep_req,
    input  logic [NTHR-1:0]   wake_req,
    output logic              disp_valid,
    output logic [TID_W-1:0]  disp_tid,
    output logic [NTHR-1:0]   disp_onehot
);
    import sched_pkg::*;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } st_t;

    st_t st_d, st_q;

    logic             slot_vld;
    logic [TID_W-1:0] slot_tid;
    logic [NTHR-1:0]  parked;
    logic [NTHR-1:0]  elig;
    logic [NTHR-1:0]  soft_req;
    logic             own_hit;
    logic             rr_take;
    logic             rr_vld;
    logic [TID_W-1:0] rr_id;

    sched_slot_table #(.SLOTS(SLOTS), .TID_W(TID_W)) u_tab (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we & cfg_mode),
        .waddr (tbl_addr),
        .wvld  (tbl_own_vld),
        .wtid  (tbl_own_tid),
        .raddr (st_q.slot),
        .rvld  (slot_vld),
        .rtid  (slot_tid)
    );

    sched_wait_track #(.NTHR(NTHR)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .parked    (parked)
    );

    sched_rr_pick #(.NTHR(NTHR)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_mode),
        .req     (soft_req),
        .take    (rr_take),
        .gnt_vld (rr_vld),
        .gnt_id  (rr_id)
    );

    always_comb begin
        elig     = thr_active & ~thr_stall & ~parked;
        soft_req = '0;
        for (int t = 0; t < int'(NTHR); t++) begin
            soft_req[t] = elig[t] && (thr_mode_e'(thr_hard[t]) == MODE_SOFT);
        end
        own_hit     = !cfg_mode && slot_vld && elig[slot_tid];
        rr_take     = !cfg_mode && !own_hit;
        disp_valid  = !cfg_mode && (own_hit || rr_vld);
        disp_tid    = own_hit ? slot_tid : rr_id;
        disp_onehot = '0;
        if (disp_valid) disp_onehot[disp_tid] = 1'b1;

        st_d = st_q;
        if (cfg_mode) st_d.slot = '0;
        else          st_d.slot = st_q.slot + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: one thread at most, one-hot consistent with the index
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ($onehot(disp_onehot) && disp_onehot[disp_tid]));
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |-> (disp_onehot == '0));
    // R10: configuration blocks dispatch and rewinds the counter
    a_r10_cfg_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> !disp_valid);
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> (st_q.slot == SLOT_W'($past(st_q.slot) + 1'b1)));
    // R6: a hard thread issues only in a slot it owns
    a_r6_hard_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && thr_hard[disp_tid]) |-> (slot_vld && slot_tid == disp_tid));
    // R12 and R7: only eligible, unparked threads issue
    a_r12_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (thr_active[disp_tid] && !thr_stall[disp_tid]));
    a_r7_not_parked: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> !parked[disp_tid]);
endmodule

// File: tb/sim_mt_dispatch_sched.sv
module sim_mt_dispatch_sched;
    localparam int NTHR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b1;
    logic       tbl_we = 1'b0;
    logic [3:0] tbl_addr = '0;
    logic       tbl_own_vld = 1'b0;
    logic [1:0] tbl_own_tid = '0;
    logic [3:0] thr_hard = '0;
    logic [3:0] thr_active = '0;
    logic [3:0] thr_stall = '0;
    logic [3:0] sleep_req = '0;
    logic [3:0] wake_req = '0;
    logic       disp_valid;
    logic [1:0] disp_tid;
    logic [3:0] disp_onehot;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mt_dispatch_sched u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_own_vld(tbl_own_vld),
        .tbl_own_tid(tbl_own_tid), .thr_hard(thr_hard), .thr_active(thr_active),
        .thr_stall(thr_stall), .sleep_req(sleep_req), .wake_req(wake_req),
        .disp_valid(disp_valid), .disp_tid(disp_tid), .disp_onehot(disp_onehot)
    );

    // sample the current cycle, then move to the next negedge
    task automatic look(input string tag, input bit ev, input int et);
        logic [3:0] eoh;
        #1;
        eoh = ev ? (4'b1 << et) : 4'b0;
        n_run++;
        if (disp_valid !== ev || disp_onehot !== eoh || (ev && disp_tid !== 2'(et))) begin
            n_bad++;
            $display("FAIL %s: valid=%0b tid=%0d onehot=%b expected valid=%0b tid=%0d onehot=%b",
                     tag, disp_valid, disp_tid, disp_onehot, ev, et, eoh);
        end
        @(negedge clk);
    endtask

    task automatic enter_cfg();
        cfg_mode = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_slot(input int a, input bit v, input int t);
        tbl_we = 1'b1; tbl_addr = 4'(a); tbl_own_vld = v; tbl_own_tid = 2'(t);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic start_run();
        cfg_mode = 1'b0;
    endtask

    // R1, R10: nothing issues in configuration
    task automatic t_reset_cfg();
        thr_active = 4'b0001; thr_hard = 4'b0000;
        for (int k = 0; k < 3; k++) look("R1 R10 cfg hold", 1'b0, 0);
    endtask

    // R8 and R1: empty table after reset, one soft thread issues each cycle
    task automatic t_single_soft();
        start_run();
        for (int k = 0; k < 20; k++) look("R8 single soft", 1'b1, 0);
        enter_cfg();
    endtask

    task automatic load_hard1();
        for (int s = 0; s < 16; s += 4) put_slot(s, 1'b1, 1);
    endtask

    // R3 R5 R6: hard owner every 4th slot, two soft threads alternate
    task automatic t_mixed();
        int nxt;
        thr_hard = 4'b1010; thr_active = 4'b1111 & 4'b0111;
        thr_active[3] = 1'b0;
        nxt = 0;
        start_run();
        for (int k = 0; k < 32; k++) begin
            if (k % 4 == 0) look("R3 hard owner", 1'b1, 1);
            else begin
                look("R5 R6 soft round-robin", 1'b1, nxt);
                nxt = (nxt == 0) ? 2 : 0;
            end
        end
        enter_cfg();
    endtask

    // R4 R9 R6: no soft activity, hard cadence unchanged, bubbles elsewhere
    task automatic t_hard_alone();
        thr_hard = 4'b1010; thr_active = 4'b1010;
        start_run();
        for (int k = 0; k < 16; k++) begin
            if (k % 4 == 0) look("R4 hard cadence", 1'b1, 1);
            else            look("R9 R6 bubble", 1'b0, 0);
        end
        enter_cfg();
    endtask

    // R7: sleep hands slots to soft, wake resumes at next owned slot
    task automatic t_sleep_wake();
        thr_hard = 4'b0010; thr_active = 4'b0011;
        start_run();
        look("R7 awake slot0", 1'b1, 1);
        sleep_req = 4'b0010;
        look("R7 s1", 1'b1, 0);
        sleep_req = 4'b0000;
        look("R7 s2", 1'b1, 0);
        look("R7 s3", 1'b1, 0);
        look("R7 parked slot4 to soft", 1'b1, 0);
        look("R7 s5", 1'b1, 0);
        wake_req = 4'b0010;
        look("R7 s6", 1'b1, 0);
        wake_req = 4'b0000;
        look("R7 s7", 1'b1, 0);
        look("R7 woken slot8", 1'b1, 1);
        sleep_req = 4'b0010; wake_req = 4'b0010;
        look("R7 s9", 1'b1, 0);
        sleep_req = 4'b0000; wake_req = 4'b0000;
        look("R7 s10", 1'b1, 0);
        look("R7 s11", 1'b1, 0);
        look("R7 wake wins slot12", 1'b1, 1);
        enter_cfg();
    endtask

    // R12: a stalled or inactive owner yields its slot
    task automatic t_stall();
        thr_hard = 4'b0010; thr_active = 4'b0011;
        start_run();
        thr_stall = 4'b0010;
        look("R12 stalled owner", 1'b1, 0);
        thr_stall = 4'b0000;
        for (int k = 1; k < 4; k++) look("R12 s", 1'b1, 0);
        thr_active = 4'b0001;
        look("R12 inactive owner", 1'b1, 0);
        thr_active = 4'b0011;
        for (int k = 5; k < 8; k++) look("R12 s", 1'b1, 0);
        look("R12 owner back", 1'b1, 1);
        enter_cfg();
    endtask

    // R10: writes outside configuration are ignored
    task automatic t_write_ignored();
        thr_hard = 4'b1010; thr_active = 4'b1011;
        start_run();
        tbl_we = 1'b1; tbl_addr = 4'd1; tbl_own_vld = 1'b1; tbl_own_tid = 2'd3;
        look("R10 slot0", 1'b1, 1);
        tbl_we = 1'b0;
        look("R10 write ignored slot1", 1'b1, 0);
        for (int k = 2; k < 16; k++) look("R10 s", 1'b1, (k % 4 == 0) ? 1 : 0);
        look("R10 wrap slot0", 1'b1, 1);
        look("R10 still ignored slot1", 1'b1, 0);
        enter_cfg();
    endtask

    // R11 R5 R3: soft reservation does not move the round-robin pointer
    task automatic t_reserve();
        for (int s = 0; s < 16; s += 4) put_slot(s, 1'b0, 0);
        put_slot(2, 1'b1, 2);
        thr_hard = 4'b0000; thr_active = 4'b0111;
        start_run();
        look("R5 rr first", 1'b1, 0);
        look("R5 rr next", 1'b1, 1);
        look("R3 soft reserved", 1'b1, 2);
        look("R11 pointer held", 1'b1, 2);
        look("R11 wrap", 1'b1, 0);
        look("R11 after wrap", 1'b1, 1);
        enter_cfg();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_cfg();
        t_single_soft();
        load_hard1();
        t_mixed();
        t_hard_alone();
        t_sleep_wake();
        t_stall();
        t_write_ignored();
        t_reserve();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule